// File: doc/BRIEF.md
# Infrared Pulse Codec

This block sits between an asynchronous serial engine and an infrared transceiver. Outbound, it turns a level-coded (NRZ) bit stream into narrow light pulses. A 0 bit is sent as a high pulse one quarter of a bit-cell long, and a 1 bit sends no pulse. Inbound, it watches the optical receiver for low-going pulses and widens each one into a full bit-time 0 on a clean NRZ line for the receiver. All timing comes from a single-cycle tick at sixteen times the bit rate. The tick drives a bit-cell phase counter that starts from zero at reset.

When the codec enable is cleared, both directions pass the NRZ level through a register and the conversion is bypassed. While the enable is set, a request line asks the frame transmitter to open every frame with two flags.

Top module: `irpc_codec`

## Requirements
- R1: During reset, `tx_ir_o` is 0, `rx_nrz_o` is 1 and the cell phase is 0.
- R2: The cell phase advances by one on each cycle with `tick_i` high and wraps after 16 ticks. A new bit-cell starts on the 16th, 32nd, ... tick after reset, and `tx_nrz_i` is captured on that same tick. The partial cell that follows reset counts as a 1 bit.
- R3: With the enable set, a captured 0 bit drives `tx_ir_o` high from the clock after the cell-start tick until the clock after the 4th following tick. The pulse covers exactly 4 ticks at the start of the cell.
- R4: With the enable set, a captured 1 bit keeps `tx_ir_o` low for the whole cell.
- R5: With the enable set, a falling edge on `rx_ir_i` passes through a 2-flop synchronizer and drives `rx_nrz_o` low 3 clocks after the input change. The output stays low for exactly 16 ticks, however long the input stays low.
- R6: A new falling edge while the output is still stretched restarts the 16-tick count.
- R7: With the enable set, `rx_nrz_o` idles at 1, and a rising edge on `rx_ir_i` has no effect on it.
- R8: With the enable cleared, `tx_ir_o` equals `tx_nrz_i` one clock later, and `rx_nrz_o` equals `rx_ir_i` three clocks later.
- R9: `two_flags_o` is high exactly while `en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe at 16x the bit rate |
| en_i | input | 1 | 1 = pulse coding active, 0 = NRZ bypass |
| tx_nrz_i | input | 1 | NRZ bit stream from the transmitter |
| tx_ir_o | output | 1 | Pulse stream to the optical emitter |
| rx_ir_i | input | 1 | Pulse stream from the optical receiver, active low |
| rx_nrz_o | output | 1 | Rebuilt NRZ stream for the receiver |
| two_flags_o | output | 1 | Request to send two opening flags |

## Verification
A wrong cell phase or a wrong captured bit shows up on `tx_ir_o` within one bit-cell. The pulse then lands on the wrong ticks, has the wrong width, or appears for a 1 bit. The bench compares every clock against a tick-count model over a long pseudo-random bit stream. A bad stretch counter shows up on `rx_nrz_o` at the end of the current stretch, as a low time other than 16 ticks or a missed restart. The bench sweeps the input pulse width from one clock to well past a bit-time, with and without a retrigger.

// File: rtl/irpc_pkg.sv
package irpc_pkg;
  // next bit-cell phase for an oversampling ratio of os
  function automatic int unsigned phase_after(input int unsigned ph, input int unsigned os);
    return (ph == os - 1) ? 0 : ph + 1;
  endfunction

  // high-pulse window covers the first width phases of a cell
  function automatic logic in_window(input int unsigned ph, input int unsigned width);
    return ph < width;
  endfunction
endpackage

// File: rtl/irpc_phase.sv
module irpc_phase #(
  parameter int OVERSAMPLE = 16,
  localparam int PW = $clog2(OVERSAMPLE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic [PW-1:0] ph_next_o,
  output logic          cell_start_o
);
  import irpc_pkg::*;
  logic [PW-1:0] ph_q;

  assign ph_next_o    = PW'(phase_after(int'(ph_q), OVERSAMPLE));
  assign cell_start_o = tick_i && (ph_next_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= '0;
    else if (tick_i) ph_q <= ph_next_o;
  end
endmodule

// File: rtl/irpc_tx.sv
module irpc_tx #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 4,
  localparam int PW = $clog2(OVERSAMPLE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          cell_start_i,
  input  logic [PW-1:0] ph_next_i,
  input  logic          nrz_i,
  output logic          ir_o,
  output logic          cur_bit_o
);
  import irpc_pkg::*;
  logic bit_q, ir_q, pulse_next;

  assign cur_bit_o  = cell_start_i ? nrz_i : bit_q;
  assign pulse_next = in_window(int'(ph_next_i), PULSE_TICKS) && !cur_bit_o;
  assign ir_o       = ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b1;
      ir_q  <= 1'b0;
    end else begin
      if (cell_start_i) bit_q <= nrz_i;
      if (!en_i)        ir_q  <= nrz_i;
      else if (tick_i)  ir_q  <= pulse_next;
    end
  end
endmodule

// File: rtl/irpc_rx.sv
module irpc_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(OVERSAMPLE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic ir_i,
  output logic nrz_o,
  output logic fall_o,
  output logic busy_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic          prev_q, out_q;
  logic [CW-1:0] cnt_q, cnt_next;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= ir_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  wire sync_w = sync_q[SYNC_STAGES-1];
  assign fall_o = prev_q && !sync_w;
  assign busy_o = (cnt_q != '0);
  assign nrz_o  = out_q;

  always_comb begin
    if (!en_i)                   cnt_next = '0;
    else if (fall_o)             cnt_next = CW'(OVERSAMPLE);
    else if (tick_i && busy_o)   cnt_next = cnt_q - 1'b1;
    else                         cnt_next = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      prev_q <= sync_w;
      cnt_q  <= cnt_next;
      out_q  <= en_i ? (cnt_next == '0) : sync_w;
    end
  end
endmodule

// File: rtl/irpc_codec.sv
module irpc_codec #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(OVERSAMPLE)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  logic tx_nrz_i,
  output logic tx_ir_o,
  input  logic rx_ir_i,
  output logic rx_nrz_o,
  output logic two_flags_o
);
  logic [PW-1:0] ph_next;
  logic cell_start, tx_cur_bit, rx_fall, rx_busy;

  irpc_phase #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .ph_next_o(ph_next), .cell_start_o(cell_start));

  irpc_tx #(.OVERSAMPLE(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i),
    .cell_start_i(cell_start), .ph_next_i(ph_next), .nrz_i(tx_nrz_i),
    .ir_o(tx_ir_o), .cur_bit_o(tx_cur_bit));

  irpc_rx #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .ir_i(rx_ir_i),
    .nrz_o(rx_nrz_o), .fall_o(rx_fall), .busy_o(rx_busy));

  assign two_flags_o = en_i;
endmodule

// File: rtl/irpc_checker.sv
module irpc_checker #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic en_i,
  input logic tx_nrz_i,
  input logic tx_ir_o,
  input logic rx_nrz_o,
  input logic two_flags_o,
  input logic cell_start,
  input logic rx_fall,
  input logic rx_busy
);
  logic [7:0] hi_ticks, low_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_ticks  <= '0;
      low_ticks <= '0;
    end else begin
      if (!tx_ir_o || !en_i)               hi_ticks <= '0;
      else if (tick_i && hi_ticks != 8'hff) hi_ticks <= hi_ticks + 1'b1;
      if (rx_fall)                          low_ticks <= '0;
      else if (tick_i && !rx_nrz_o && low_ticks != 8'hff) low_ticks <= low_ticks + 1'b1;
    end
  end

  a_r1_reset_vals: assert property (@(posedge clk) !rst_n |=> (!tx_ir_o && rx_nrz_o));
  a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= 8'(PULSE_TICKS));
  a_r3_zero_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    (cell_start && !tx_nrz_i) |=> tx_ir_o);
  a_r4_one_stays_low: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    (cell_start && tx_nrz_i) |=> !tx_ir_o);
  a_r5_fall_goes_low: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    rx_fall |=> !rx_nrz_o);
  a_r5_stretch_len: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    ($past(en_i) && $rose(rx_nrz_o)) |-> low_ticks == 8'(OVERSAMPLE));
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
    (!rx_busy && !rx_fall) |=> rx_nrz_o);
  a_r8_tx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> tx_ir_o == $past(tx_nrz_i));
  a_r9_flag_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> two_flags_o);
endmodule

bind irpc_codec irpc_checker #(.OVERSAMPLE(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i), .tx_nrz_i(tx_nrz_i),
  .tx_ir_o(tx_ir_o), .rx_nrz_o(rx_nrz_o), .two_flags_o(two_flags_o),
  .cell_start(cell_start), .rx_fall(rx_fall), .rx_busy(rx_busy));

// File: tb/sim_irpc_codec.sv
module sim_irpc_codec;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int OS         = 16;
  localparam int PULSE      = 4;
  localparam int TX_CELLS   = 300;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, en = 1'b0;
  logic man_tx = 1'b1, rx_ir = 1'b1, sweep_on = 1'b0, sweep_bit = 1'b1;
  logic tx_ir, rx_nrz, two_flags;
  wire  tx_nrz = sweep_on ? sweep_bit : man_tx;
  int total = 0, bad = 0, m = 0, cycles = 0, divc = 0, last_cell = -1;
  logic mb = 1'b1;
  logic [6:0] lfsr = 7'h5a;

  always #(CLK_PERIOD/2) clk = ~clk;

  irpc_codec u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en),
    .tx_nrz_i(tx_nrz), .tx_ir_o(tx_ir), .rx_ir_i(rx_ir), .rx_nrz_o(rx_nrz),
    .two_flags_o(two_flags));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bench tick-count model: ticks consumed since reset, bit captured per cell (R2)
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin m = 0; mb = 1'b1; end
    else if (tick) begin
      if ((m + 1) % OS == 0) mb = tx_nrz;
      m++;
    end
  end

  // tx model check and tick generation, away from the rising edge
  always @(negedge clk) begin
    if (sweep_on && en && rst_n) begin
      logic exp_ir;
      exp_ir = !mb && ((m % OS) < PULSE);
      if (mb) chk(tx_ir == exp_ir, "R4", int'(tx_ir), int'(exp_ir));
      else    chk(tx_ir == exp_ir, "R3", int'(tx_ir), int'(exp_ir));
      if ((m % OS) >= 8 && (m / OS) != last_cell) begin
        last_cell = m / OS;
        lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        sweep_bit = lfsr[0];
      end
    end
    tick = (divc == TICK_DIV - 1);
    divc = (divc + 1) % TICK_DIV;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(tx_ir == 1'b0, "R1", int'(tx_ir), 0);
    chk(rx_nrz == 1'b1, "R1", int'(rx_nrz), 1);
    rst_n = 1'b1;
  endtask

  // drive one low pulse of width clocks, optionally retrigger after k low ticks
  task automatic rx_pulse(input int width, input int retrig_k, input int exp_ticks);
    int cnt = 0, rel_at = -1;
    logic seen_low = 1'b0, done = 1'b0, relow = 1'b0, retrig_done = 1'b0;
    do step(); while (!tick);
    rx_ir = 1'b0;
    for (int i = 1; i < width + 260; i++) begin
      step();
      if (i == width)  rx_ir = 1'b1;
      if (i == rel_at) rx_ir = 1'b1;
      if (i == 2) chk(rx_nrz == 1'b1, "R5", int'(rx_nrz), 1);
      if (i == 3) chk(rx_nrz == 1'b0, "R5", int'(rx_nrz), 0);
      if (!rx_nrz) begin
        if (done) relow = 1'b1;
        seen_low = 1'b1;
        if (tick) begin
          cnt++;
          if (retrig_k > 0 && cnt == retrig_k && !retrig_done) begin
            retrig_done = 1'b1;
            rx_ir = 1'b0;
            rel_at = i + 2;
          end
        end
      end else if (seen_low) done = 1'b1;
    end
    rx_ir = 1'b1;
    if (retrig_k > 0) chk(cnt == exp_ticks, "R6", cnt, exp_ticks);
    else              chk(cnt == exp_ticks, "R5", cnt, exp_ticks);
    chk(!relow, "R7", int'(relow), 0);
  endtask

  initial begin
    do_reset();
    en = 1'b0;
    step();
    chk(two_flags == 1'b0, "R9", int'(two_flags), 0);
    // R8 bypass in both directions
    for (int v = 0; v < 8; v++) begin
      man_tx = v[0]; rx_ir = v[1] ^ v[2];
      step();
      chk(tx_ir == man_tx, "R8", int'(tx_ir), int'(man_tx));
      step(); step();
      chk(rx_nrz == rx_ir, "R8", int'(rx_nrz), int'(rx_ir));
    end
    rx_ir = 1'b1; man_tx = 1'b1;
    do_reset();
    en = 1'b1;
    step();
    chk(two_flags == 1'b1, "R9", int'(two_flags), 1);
    // R2 R3 R4: long pseudo-random stream checked every clock
    sweep_on = 1'b1;
    while (m < TX_CELLS * OS) step();
    sweep_on = 1'b0;
    // R7: idle and no reaction to a lone rising edge
    repeat (20) step();
    chk(rx_nrz == 1'b1, "R7", int'(rx_nrz), 1);
    // R5 width sweep, including lows longer than a bit time
    for (int w = 1; w <= 24; w++) rx_pulse(w, 0, OS);
    rx_pulse(200, 0, OS);
    // R6 retrigger at several points in the stretch
    for (int k = 1; k <= 15; k += 2) rx_pulse(2, k, k + OS);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule